// File: doc/BRIEF.md
# Flash Bank Status and Interrupt Unit

This block keeps the status picture of one flash bank. Four level indicators come straight from the bank controller and are shown live: busy, operation queued, write buffer partly filled, and CRC engine running. Eleven sticky event flags latch one-cycle event pulses from the controller and stay set until software acknowledges them. Software acknowledges a flag by writing a 1 to the matching bit of a separate clear register. Writing to the status word itself changes nothing.

Each sticky flag has its own interrupt enable bit. All enabled flags are merged into a single registered interrupt line. The CRC read-error term is special: it counts only while the CRC-done flag is also set, because a read error seen during a CRC pass means nothing until that pass has finished. Access goes through a plain register port with a write strobe, a 2-bit word address, write data and combinational read data.

Top module: `fbank_stat_irq`

## Requirements
- R1: Status word (address 0) bits 3:0 show busy_i, queue_pend_i, wbuf_pend_i, crc_run_i live, in that order. No register write can force these bits.
- R2: A 1 on evt_i[i] at a clock edge sets sticky flag i, which reads back at status bit 4+i. The flag stays set after the pulse ends. Flag order by index: 0 program done, 1 write-protect error, 2 sequence error, 3 strobe error, 4 inconsistency error, 5 read-protect error, 6 secure-read error, 7 ECC single correction, 8 ECC double detection, 9 CRC done, 10 CRC read error.
- R3: Writing 1 to bit i of the clear register (address 2) clears flag i at that edge. Bits written as 0 leave their flags unchanged.
- R4: If an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R5: Writes to the status address (address 0) and to address 3 change no flag and no enable bit.
- R6: irq_o is high one cycle after any flag i whose enable bit i (address 1) is set goes high. It falls one cycle after the last such term goes away, whether that is because the flag was cleared or because the enable was dropped.
- R7: The CRC read-error flag (index 10) drives the interrupt only while the CRC-done flag (index 9) is also set.
- R8: The enable register reads back bits 10:0 as last written, with the upper bits reading 0. The clear register and address 3 always read 0.
- R9: A new event on an already-set flag leaves it set. No clear is needed between operations.
- R10: After reset all flags and enables are 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Bank operation in progress |
| queue_pend_i | input | 1 | Operation waiting in the command queue |
| wbuf_pend_i | input | 1 | Write buffer waiting for more data |
| crc_run_i | input | 1 | CRC computation in progress |
| evt_i | input | 11 | One-cycle event pulses, one per sticky flag |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address: 0 status, 1 enable, 2 clear |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Merged interrupt request |

## Verification
A flag stuck or lost inside the block appears in the very next status read, since read data is combinational. It also appears on irq_o one edge later once that flag is enabled. A wrong clear mask or a wrong set-versus-clear priority shows up as a status bit that differs from the expected value right after the write edge. A fault in the CRC gating can be seen only in the cycle after the CRC read-error flag and its enable are both set while CRC-done is still clear, so the bench sets up exactly that ordering.

// File: rtl/fbank_pkg.sv
package fbank_pkg;
  localparam int unsigned LIVE_N = 4;
  localparam int unsigned EVT_N  = 11;

  localparam int unsigned F_PROG_DONE = 0;
  localparam int unsigned F_CRC_DONE  = 9;
  localparam int unsigned F_CRC_RDERR = 10;

  typedef enum logic [1:0] {
    A_STATUS = 2'd0,
    A_ENABLE = 2'd1,
    A_CLEAR  = 2'd2,
    A_SPARE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/fbank_flag_bank.sv
module fbank_flag_bank #(
  parameter int unsigned N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;   // set has priority
      else if (clr_i[g]) q <= 1'b0;
    end
    assign flag_o[g] = q;
  end
endmodule

// File: rtl/fbank_regport.sv
module fbank_regport
  import fbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LIVE_N-1:0] live_i,
  input  logic [EVT_N-1:0]  flag_i,
  output logic [EVT_N-1:0]  en_o,
  output logic [EVT_N-1:0]  clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [EVT_N-1:0] en_q;
  logic             en_we;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:EVT_N];
  assign en_we = we_i && (reg_addr_e'(addr_i) == A_ENABLE);
  assign clr_o = (we_i && (reg_addr_e'(addr_i) == A_CLEAR)) ? wdata_i[EVT_N-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (en_we) en_q <= wdata_i[EVT_N-1:0];
  end
  assign en_o = en_q;

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      A_STATUS: rdata_o = DATA_W'({flag_i, live_i});
      A_ENABLE: rdata_o = DATA_W'(en_q);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/fbank_irq_merge.sv
module fbank_irq_merge
  import fbank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_N-1:0] flag_i,
  input  logic [EVT_N-1:0] en_i,
  output logic             irq_o
);
  logic [EVT_N-1:0] term;
  logic             irq_q;

  always_comb begin
    term = flag_i & en_i;
    // read error is only valid once the CRC pass has ended
    term[F_CRC_RDERR] = term[F_CRC_RDERR] & flag_i[F_CRC_DONE];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |term;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/fbank_stat_irq.sv
module fbank_stat_irq
  import fbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                busy_i,
  input  logic                queue_pend_i,
  input  logic                wbuf_pend_i,
  input  logic                crc_run_i,
  input  logic [EVT_N-1:0]    evt_i,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                irq_o
);
  logic [LIVE_N-1:0] live;
  logic [EVT_N-1:0]  flag_q;
  logic [EVT_N-1:0]  en_q;
  logic [EVT_N-1:0]  clr_vec;

  assign live = {crc_run_i, wbuf_pend_i, queue_pend_i, busy_i};

  fbank_regport #(.DATA_W(DATA_W)) u_regport (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .live_i  (live),
    .flag_i  (flag_q),
    .en_o    (en_q),
    .clr_o   (clr_vec),
    .rdata_o (reg_rdata_o)
  );

  fbank_flag_bank #(.N(EVT_N)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_i),
    .clr_i  (clr_vec),
    .flag_o (flag_q)
  );

  fbank_irq_merge u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i (flag_q),
    .en_i   (en_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/fbank_stat_irq_chk.sv
module fbank_stat_irq_chk
  import fbank_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [EVT_N-1:0] evt_i,
  input logic [EVT_N-1:0] clr_vec,
  input logic [EVT_N-1:0] flag_q,
  input logic [EVT_N-1:0] en_q,
  input logic             irq_o
);
  logic [EVT_N-1:0] gated;
  always_comb begin
    gated = flag_q & en_q;
    if (!flag_q[F_CRC_DONE]) gated[F_CRC_RDERR] = 1'b0;
  end

  a_r2_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(flag_q) & ~$past(clr_vec) & ~flag_q) == '0));

  a_r3_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(clr_vec) & ~$past(evt_i) & flag_q) == '0));

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(evt_i) & ~flag_q) == '0));

  a_r6_irq_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|gated)));

  a_r7_crc_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & en_q) == (EVT_N'(1) << F_CRC_RDERR)) && !flag_q[F_CRC_DONE] |=> !irq_o);
endmodule

bind fbank_stat_irq fbank_stat_irq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .evt_i   (evt_i),
  .clr_vec (clr_vec),
  .flag_q  (flag_q),
  .en_q    (en_q),
  .irq_o   (irq_o)
);

// File: tb/fbank_stat_irq_tb.sv
module fbank_stat_irq_tb;
  localparam int NE = 11;
  localparam logic [1:0] AS = 2'd0, AE = 2'd1, AC = 2'd2, AX = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busy = 0, qpend = 0, wbuf = 0, crcrun = 0;
  logic [NE-1:0] evt = '0;
  logic        we = 0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  fbank_stat_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .queue_pend_i(qpend),
    .wbuf_pend_i(wbuf), .crc_run_i(crcrun), .evt_i(evt), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; wdata = '0;
  endtask

  task automatic pulse(input logic [NE-1:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = '0;
  endtask

  function automatic logic [31:0] st(input logic [NE-1:0] f, input logic [3:0] l);
    return {17'd0, f, l};
  endfunction

  task automatic scrub();
    wr(AE, '0); wr(AC, 32'h7FF); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(AS, d); chk("R10 status", d, 32'h0);
    rd(AE, d); chk("R10 enable", d, 32'h0);
    chk("R10 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_live();
    logic [31:0] d;
    busy = 1; wbuf = 1; rd(AS, d); chk("R1 live 0101", d, st('0, 4'b0101));
    busy = 0; qpend = 1; crcrun = 1; wbuf = 0; rd(AS, d); chk("R1 live 1010", d, st('0, 4'b1010));
    wr(AS, 32'h0); wr(AC, 32'hFFFF_FFFF);
    rd(AS, d); chk("R1 live unforced", d, st('0, 4'b1010));
    qpend = 0; crcrun = 0; rd(AS, d); chk("R1 live drop", d, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    for (int i = 0; i < NE; i++) begin
      pulse(NE'(1) << i);
      @(negedge clk);
      rd(AS, d); chk($sformatf("R2 flag %0d held", i), d, st(NE'(1) << i, 4'h0));
      wr(AC, 32'(1) << i);
    end
  endtask

  task automatic t_clear();
    logic [31:0] d;
    pulse(11'h0A5);
    wr(AC, 32'h0); rd(AS, d); chk("R3 zero write", d, st(11'h0A5, 4'h0));
    wr(AC, 32'h004); rd(AS, d); chk("R3 one bit", d, st(11'h0A1, 4'h0));
    wr(AC, 32'h7FF); rd(AS, d); chk("R3 all", d, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk); evt = 11'h002; we = 1; addr = AC; wdata = 32'h003;
    @(negedge clk); evt = '0; we = 0; wdata = '0;
    rd(AS, d); chk("R4 set wins", d, st(11'h002, 4'h0));
    scrub();
  endtask

  task automatic t_status_write();
    logic [31:0] d;
    pulse(11'h300); wr(AE, 32'h055);
    wr(AS, 32'hFFFF_FFFF); wr(AX, 32'hFFFF_FFFF); wr(AS, 32'h0);
    rd(AS, d); chk("R5 flags kept", d, st(11'h300, 4'h0));
    rd(AE, d); chk("R5 enable kept", d, 32'h055);
    scrub();
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(AE, 32'hFFFF_F6A5); rd(AE, d); chk("R8 enable rb", d, 32'h6A5);
    rd(AC, d); chk("R8 clear reads 0", d, 32'h0);
    rd(AX, d); chk("R8 spare reads 0", d, 32'h0);
    scrub();
  endtask

  task automatic t_irq();
    wr(AE, 32'h002);
    pulse(11'h001); @(negedge clk); @(negedge clk);
    chk("R6 disabled flag no irq", {31'd0, irq}, 0);
    pulse(11'h002);
    chk("R6 irq not yet", {31'd0, irq}, 0);
    @(negedge clk); chk("R6 irq up", {31'd0, irq}, 1);
    wr(AE, 32'h0); chk("R6 irq still up", {31'd0, irq}, 1);
    @(negedge clk); chk("R6 irq off on disable", {31'd0, irq}, 0);
    wr(AE, 32'h002); @(negedge clk); chk("R6 irq back", {31'd0, irq}, 1);
    wr(AC, 32'h002); @(negedge clk); chk("R6 irq off on clear", {31'd0, irq}, 0);
    scrub();
  endtask

  task automatic t_crc_gate();
    wr(AE, 32'h400);
    pulse(11'h400); @(negedge clk); @(negedge clk);
    chk("R7 rderr alone gated", {31'd0, irq}, 0);
    pulse(11'h200); @(negedge clk);
    chk("R7 rderr with done", {31'd0, irq}, 1);
    wr(AC, 32'h200); @(negedge clk);
    chk("R7 done cleared", {31'd0, irq}, 0);
    scrub();
  endtask

  task automatic t_reevent();
    logic [31:0] d;
    pulse(11'h201); pulse(11'h201);
    rd(AS, d); chk("R9 re-event", d, st(11'h201, 4'h0));
    scrub();
  endtask

  initial begin
    #2;
    t_reset();
    @(negedge clk); rst_n = 1;
    t_live(); t_sticky(); t_clear(); t_set_wins(); t_status_write();
    t_readback(); t_irq(); t_crc_gate(); t_reevent();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule